// File: doc/BRIEF.md
# Hashed Page Table Walker

This block refills a translation buffer after a miss. It is given one miss at a time: the access kind, the effective address that missed, a compare word, the addresses of a primary and a secondary entry group, and a protection key bit. Hash computation, segment lookup and the translation buffer itself sit outside the block. The block walks the hashed page table in memory through a word-read port and looks for an entry whose first word equals the compare word.

When it finds a match it reads the entry's second word. It then checks the guard bit for instruction fetches and the protection field for stores, and keeps the referenced and changed bits up to date. It writes the low halfword back only when one of those bits changes. It ends either by loading the translation buffer with the second word and the miss address, or by raising a fault that carries a status code, the miss address and the access kind.

Top module: `ptw_walker`

## Requirements
- R1: One group holds 8 entries of 8 bytes. The first words are read in order at group base + 8*i for i = 0..7, and the scan stops at the first word equal to the active compare word.
- R2: If no primary entry matches and bit 6 (0x40) of the compare word is clear, the secondary group is scanned the same way with that bit set in the compare word. If the bit was already set, the walk ends as not found after the primary scan alone.
- R3: After a match, the word at entry + 4 is read. A successful walk gives a one-cycle `tlb_we` with `tlb_ea` equal to the miss address and `tlb_pte` equal to that word after any bit updates.
- R4: For a fetch (kind 2'b00), a matched second word with bit 3 set raises a fault with code 0x10000000. No buffer load and no write-back take place.
- R5: A walk that finds no match faults with code 0x40000000 for a fetch (2'b00) or a load (2'b01), and with code 0x42000000 for a store (2'b10).
- R6: For fetches and loads, if bit 8 (referenced) of the second word is clear, it is set in the loaded word and the new low 16 bits are written to byte address entry + 6. If bit 8 is already set, no write is issued.
- R7: For a store whose second word has bit 7 (changed) set, the word is loaded unchanged and no write is issued.
- R8: For a store with bit 7 clear, the protection field (bits 1:0) decides. 2'b10 is allowed. 2'b11 faults with code 0x0A000000. 2'b00 and 2'b01 are allowed when the key input is 0 and fault with 0x0A000000 when it is 1.
- R9: An allowed store with bit 7 clear sets bits 8 and 7 (0x180) in the loaded word and writes its low 16 bits to entry + 6.
- R10: A fault is a one-cycle `flt_valid` with `flt_code`, `flt_ea` (the miss address) and `flt_kind`. No `tlb_we` is given for that walk.
- R11: `rd_req` is a one-cycle strobe. No new strobe is issued until `rd_valid` has returned the previous word.
- R12: `busy` rises in the cycle after a miss is accepted and falls after the terminating pulse. A `miss_valid` seen while busy has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request strobe, taken only when idle |
| miss_kind | input | 2 | 00 fetch, 01 load, 10 store |
| miss_ea | input | 32 | Effective address that missed |
| miss_cmp | input | 32 | Compare word for the primary scan |
| miss_grp1 | input | 32 | Primary group base address |
| miss_grp2 | input | 32 | Secondary group base address |
| miss_key | input | 1 | Protection key for stores |
| rd_req | output | 1 | Read strobe |
| rd_addr | output | 32 | Read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Halfword write strobe |
| wr_addr | output | 32 | Halfword byte address |
| wr_half | output | 16 | Halfword data |
| tlb_we | output | 1 | Translation buffer load strobe |
| tlb_ea | output | 32 | Address to load |
| tlb_pte | output | 32 | Entry word to load |
| flt_valid | output | 1 | Fault strobe |
| flt_code | output | 32 | Fault status code |
| flt_ea | output | 32 | Faulting address |
| flt_kind | output | 2 | Faulting access kind |
| busy | output | 1 | Walk in progress |

## Verification
A wrong slot index or group base shows up on the very next `rd_req` as an unexpected address. A compare word that is missing its secondary bit shows up as an extra primary pass or a premature fault. These errors therefore appear within one memory round trip of the fault. Errors in the decision on the second word appear in the terminating cycle, as a wrong code, a wrong loaded word, or a write-back that is missing or spurious. A walk that latched a second request while busy shows up as a mismatched address on the terminating strobe.

// File: rtl/ptw_pkg.sv
// Shared encodings for the hashed page table walker.
// Assumes 32-bit words with big-endian halfword placement in memory.
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10
    } acc_e;

    localparam int REF_BIT   = 8;
    localparam int CHG_BIT   = 7;
    localparam int GUARD_BIT = 3;
    localparam int SEC_BIT   = 6;

    localparam logic [31:0] CODE_GUARD    = 32'h1000_0000;
    localparam logic [31:0] CODE_NOTFOUND = 32'h4000_0000;
    localparam logic [31:0] CODE_NF_STORE = 32'h4200_0000;
    localparam logic [31:0] CODE_PROT     = 32'h0A00_0000;

    // Status code for a walk that found no entry.
    function automatic logic [31:0] notfound_code(input logic [1:0] kind);
        return (kind == ACC_STORE) ? CODE_NF_STORE : CODE_NOTFOUND;
    endfunction
endpackage

// File: rtl/ptw_cursor.sv
// Slot cursor: holds the current group base and slot index and derives the
// tag, data-word and write-back byte addresses of the current entry.
// Assumes ENTRIES is a power of two.
module ptw_cursor #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          step,
    output logic [AW-1:0] tag_addr,
    output logic [AW-1:0] pte_addr,
    output logic [AW-1:0] wb_addr,
    output logic          last
);
    localparam int IW         = $clog2(ENTRIES);
    localparam int WORD_BYTES = DW / 8;
    localparam int HALF_BYTES = DW / 16;

    logic [AW-1:0] base_q;
    logic [IW-1:0] idx_q;

    // Restart at slot 0 of a new group, or advance one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            idx_q  <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Byte addresses of the current entry's fields.
    always_comb begin
        tag_addr = base_q + AW'(idx_q) * AW'(ENTRY_BYTES);
        pte_addr = tag_addr + AW'(WORD_BYTES);
        wb_addr  = pte_addr + AW'(HALF_BYTES);
        last     = (idx_q == IW'(ENTRIES - 1));
    end
endmodule

// File: rtl/ptw_judge.sv
// Entry judge: from the matched second word, the access kind and the key,
// decides fault or load, the word to load and whether to write back.
// Purely combinational; the caller registers its result.
module ptw_judge #(
    parameter int DW = 32
) (
    input  logic [1:0]    kind,
    input  logic [DW-1:0] pte,
    input  logic          key,
    output logic          fault,
    output logic [31:0]   code,
    output logic          need_wb,
    output logic [DW-1:0] pte_out
);
    import ptw_pkg::*;

    localparam logic [DW-1:0] REF_M = DW'(1) << REF_BIT;
    localparam logic [DW-1:0] CHG_M = DW'(1) << CHG_BIT;

    logic [1:0] pp;
    logic       store_ok;

    // Guard, protection and referenced/changed policy per access kind.
    always_comb begin
        pp       = pte[1:0];
        store_ok = (pp == 2'b10) || (!pp[1] && !key);
        fault    = 1'b0;
        code     = '0;
        need_wb  = 1'b0;
        pte_out  = pte;
        if (acc_e'(kind) == ACC_STORE) begin
            if (!pte[CHG_BIT]) begin
                if (store_ok) begin
                    pte_out = pte | REF_M | CHG_M;
                    need_wb = 1'b1;
                end else begin
                    fault = 1'b1;
                    code  = CODE_PROT;
                end
            end
        end else if (acc_e'(kind) == ACC_FETCH && pte[GUARD_BIT]) begin
            fault = 1'b1;
            code  = CODE_GUARD;
        end else if (!pte[REF_BIT]) begin
            pte_out = pte | REF_M;
            need_wb = 1'b1;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
// Hashed page table walker top: sequences the two-pass group search over a
// one-outstanding word-read port, then loads the buffer or raises a fault.
// Assumes memory answers each rd_req strobe with exactly one rd_valid.
module ptw_walker #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [1:0]    miss_kind,
    input  logic [AW-1:0] miss_ea,
    input  logic [DW-1:0] miss_cmp,
    input  logic [AW-1:0] miss_grp1,
    input  logic [AW-1:0] miss_grp2,
    input  logic          miss_key,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW/2-1:0] wr_half,
    output logic          tlb_we,
    output logic [AW-1:0] tlb_ea,
    output logic [DW-1:0] tlb_pte,
    output logic          flt_valid,
    output logic [31:0]   flt_code,
    output logic [AW-1:0] flt_ea,
    output logic [1:0]    flt_kind,
    output logic          busy
);
    import ptw_pkg::*;

    typedef enum logic [2:0] {
        S_IDLE, S_TAG_REQ, S_TAG_WAIT, S_PTE_REQ, S_PTE_WAIT, S_COMMIT, S_FAULT
    } state_e;

    state_e        state_q;
    logic [1:0]    kind_q;
    logic [AW-1:0] ea_q;
    logic [DW-1:0] cmp_q;
    logic [AW-1:0] grp2_q;
    logic          key_q;
    logic [DW-1:0] pte_q;
    logic          wb_q;
    logic [31:0]   code_q;

    logic          cur_load, cur_step, cur_last;
    logic [AW-1:0] cur_base, tag_addr, pte_addr, wb_addr;
    logic          j_fault, j_wb;
    logic [31:0]   j_code;
    logic [DW-1:0] j_pte;
    logic          tag_hit;

    ptw_cursor #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(cur_load), .base_in(cur_base), .step(cur_step),
        .tag_addr(tag_addr), .pte_addr(pte_addr), .wb_addr(wb_addr), .last(cur_last)
    );

    ptw_judge #(.DW(DW)) u_judge (
        .kind(kind_q), .pte(rd_data), .key(key_q),
        .fault(j_fault), .code(j_code), .need_wb(j_wb), .pte_out(j_pte)
    );

    // Cursor control: new group on accept or on the secondary retry.
    always_comb begin
        tag_hit  = (rd_data == cmp_q);
        cur_load = 1'b0;
        cur_step = 1'b0;
        cur_base = miss_grp1;
        if (state_q == S_IDLE && miss_valid) begin
            cur_load = 1'b1;
        end else if (state_q == S_TAG_WAIT && rd_valid && !tag_hit) begin
            if (!cur_last) begin
                cur_step = 1'b1;
            end else if (!cmp_q[SEC_BIT]) begin
                cur_load = 1'b1;
                cur_base = grp2_q;
            end
        end
    end

    // Walk sequencer and captured miss context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= '0;
            ea_q    <= '0;
            cmp_q   <= '0;
            grp2_q  <= '0;
            key_q   <= 1'b0;
            pte_q   <= '0;
            wb_q    <= 1'b0;
            code_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (miss_valid) begin
                    kind_q  <= miss_kind;
                    ea_q    <= miss_ea;
                    cmp_q   <= miss_cmp;
                    grp2_q  <= miss_grp2;
                    key_q   <= miss_key;
                    state_q <= S_TAG_REQ;
                end
                S_TAG_REQ: state_q <= S_TAG_WAIT;
                S_TAG_WAIT: if (rd_valid) begin
                    if (tag_hit) begin
                        state_q <= S_PTE_REQ;
                    end else if (!cur_last) begin
                        state_q <= S_TAG_REQ;
                    end else if (!cmp_q[SEC_BIT]) begin
                        cmp_q[SEC_BIT] <= 1'b1;
                        state_q        <= S_TAG_REQ;
                    end else begin
                        code_q  <= notfound_code(kind_q);
                        state_q <= S_FAULT;
                    end
                end
                S_PTE_REQ: state_q <= S_PTE_WAIT;
                S_PTE_WAIT: if (rd_valid) begin
                    pte_q   <= j_pte;
                    wb_q    <= j_wb;
                    code_q  <= j_code;
                    state_q <= j_fault ? S_FAULT : S_COMMIT;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Port drive decoded from the sequencer state.
    always_comb begin
        busy      = (state_q != S_IDLE);
        rd_req    = (state_q == S_TAG_REQ) || (state_q == S_PTE_REQ);
        rd_addr   = (state_q == S_PTE_REQ) ? pte_addr : tag_addr;
        tlb_we    = (state_q == S_COMMIT);
        tlb_ea    = ea_q;
        tlb_pte   = pte_q;
        wr_en     = (state_q == S_COMMIT) && wb_q;
        wr_addr   = wb_addr;
        wr_half   = pte_q[DW/2-1:0];
        flt_valid = (state_q == S_FAULT);
        flt_code  = code_q;
        flt_ea    = ea_q;
        flt_kind  = kind_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Port-level protocol checker for ptw_walker, attached by bind.
module ptw_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miss_valid,
    input logic          busy,
    input logic          rd_req,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          tlb_we,
    input logic          flt_valid,
    input logic [31:0]   flt_code,
    input logic [1:0]    flt_kind
);
    AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R11
    AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> busy); // R12
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && miss_valid) |=> busy); // R12
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tlb_we && flt_valid)); // R10
    AST_FLT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |=> (!flt_valid && !busy)); // R10
    AST_TLB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tlb_we |=> (!tlb_we && !busy)); // R3
    AST_WB_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> tlb_we); // R6
    AST_WB_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (wr_addr[2:0] == 3'd6)); // R9
    AST_FLT_CODE: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |->
        (flt_code == 32'h1000_0000 || flt_code == 32'h4000_0000 ||
         flt_code == 32'h4200_0000 || flt_code == 32'h0A00_0000)); // R5
    AST_GUARD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_code == 32'h1000_0000) |-> (flt_kind == 2'b00)); // R4
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .busy(busy), .rd_req(rd_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .tlb_we(tlb_we), .flt_valid(flt_valid),
    .flt_code(flt_code), .flt_kind(flt_kind)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [1:0]  miss_kind = '0;
    logic [31:0] miss_ea = '0, miss_cmp = '0, miss_grp1 = '0, miss_grp2 = '0;
    logic        miss_key = 1'b0;
    logic        rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [15:0] wr_half;
    logic        tlb_we, flt_valid, busy;
    logic [31:0] tlb_ea, tlb_pte, flt_code, flt_ea;
    logic [1:0]  flt_kind;

    int errors = 0, checks = 0, ends = 0, nreads = 0;

    ptw_walker dut (.*);

    always #5 clk = ~clk;

    // Behavioural memory and expected-outcome state.
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_rd [$];
    logic        x_fault, x_wb;
    logic [31:0] x_code, x_ea, x_pte, x_wb_addr;
    logic [1:0]  x_kind;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    // Reference model: predicts read order and the final result of a walk.
    task automatic predict(input logic [1:0] k, input logic [31:0] ea, cmp, g1, g2, input logic key);
        logic [31:0] c, base, ent, w;
        bit found = 0;
        exp_rd.delete();
        x_ea = ea; x_kind = k; x_fault = 0; x_wb = 0; x_code = 0; x_pte = 0; ent = 0;
        for (int pass = 0; pass < 2 && !found; pass++) begin
            if (pass == 1 && cmp[6]) break;
            c = (pass == 0) ? cmp : (cmp | 32'h40);
            base = (pass == 0) ? g1 : g2;
            for (int i = 0; i < 8 && !found; i++) begin
                exp_rd.push_back(base + 8 * i);
                if (peek(base + 8 * i) == c) begin found = 1; ent = base + 8 * i; end
            end
        end
        if (!found) begin
            x_fault = 1; x_code = (k == 2'b10) ? 32'h4200_0000 : 32'h4000_0000;
            return;
        end
        exp_rd.push_back(ent + 4);
        w = peek(ent + 4);
        x_wb_addr = ent + 6;
        if (k == 2'b10) begin
            if (w[7]) x_pte = w;
            else if (w[1:0] == 2'b11 || (w[1:0] != 2'b10 && key)) begin x_fault = 1; x_code = 32'h0A00_0000; end
            else begin x_pte = w | 32'h180; x_wb = 1; end
        end else if (k == 2'b00 && w[3]) begin
            x_fault = 1; x_code = 32'h1000_0000;
        end else begin
            x_pte = w | 32'h100; x_wb = !w[8];
        end
    endtask

    // Lay out a group: slot hit (or none if hit>7) carries tag, with data word pte.
    task automatic fill_group(input logic [31:0] base, input int hit, input logic [31:0] tag, pte);
        for (int j = 0; j < 8; j++) begin
            mem[base + 8 * j]     = (j == hit) ? tag : (tag ^ 32'h8000_0000 ^ (j << 12));
            mem[base + 8 * j + 4] = (j == hit) ? pte : (32'h5550_0000 | j);
        end
    endtask

    // Memory responder: one outstanding read, latency cycling 1..3.
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [31:0] a = 0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin rd_valid = 1'b1; rd_data = peek(a); pend = 0; end
                else cnt--;
            end
            if (rd_req) begin
                if (pend) check(0, "R11 read while outstanding", rd_addr, a);
                pend = 1; a = rd_addr; cnt = nreads % 3; nreads++;
            end
            if (wr_en) mem[wr_addr - 2] = {peek(wr_addr - 2) ^ 32'h0, 16'h0} | {peek(wr_addr - 2)} & 32'hFFFF_0000 | 32'(wr_half);
        end
    end

    // Monitor: compares each port event against the reference every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req) begin
                if (exp_rd.size() == 0) check(0, "R1 unexpected read", rd_addr, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(rd_addr == e, "R1/R2 read address", rd_addr, e);
                end
            end
            if (wr_en) begin
                check(x_wb, "R7 write-back not expected", wr_addr, 32'h0);
                check(wr_addr == x_wb_addr, "R6/R9 write-back address", wr_addr, x_wb_addr);
                check(wr_half == x_pte[15:0], "R6/R9 write-back data", 32'(wr_half), 32'(x_pte[15:0]));
            end
            if (tlb_we) begin
                ends++;
                check(!x_fault, "R10 load instead of fault", tlb_pte, x_code);
                check(tlb_ea == x_ea, "R12 load address", tlb_ea, x_ea);
                check(tlb_pte == x_pte, "R3 loaded word", tlb_pte, x_pte);
                if (x_wb) check(wr_en, "R6/R9 write-back missing", 32'(wr_en), 32'h1);
            end
            if (flt_valid) begin
                ends++;
                check(x_fault, "R10 fault instead of load", flt_code, 32'h0);
                check(flt_code == x_code, "R4/R5/R8 fault code", flt_code, x_code);
                check(flt_ea == x_ea, "R10 fault address", flt_ea, x_ea);
                check(flt_kind == x_kind, "R10 fault kind", 32'(flt_kind), 32'(x_kind));
            end
        end
    end

    // Issue one miss with a spurious request while busy, then await its end.
    task automatic run_miss(input logic [1:0] k, input logic [31:0] ea, cmp, g1, g2, input logic key);
        int start, waitc;
        predict(k, ea, cmp, g1, g2, key);
        start = ends;
        @(negedge clk);
        miss_valid = 1; miss_kind = k; miss_ea = ea; miss_cmp = cmp;
        miss_grp1 = g1; miss_grp2 = g2; miss_key = key;
        @(negedge clk);
        miss_valid = 0;
        @(negedge clk);
        miss_valid = 1; miss_kind = ~k; miss_ea = ~ea; miss_cmp = ~cmp;   // R12 ignored
        miss_grp1 = g2; miss_grp2 = g1; miss_key = ~key;
        @(negedge clk);
        miss_valid = 0;
        waitc = 0;
        while (ends == start && waitc < 2000) begin @(negedge clk); waitc++; end
        check(waitc < 2000, "R12 watchdog walk hung", 32'(waitc), 32'd2000);
        @(negedge clk);
        check(!busy, "R12 busy after end", 32'(busy), 32'h0);
        check(exp_rd.size() == 0, "R1 reads missing", 32'(exp_rd.size()), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !rd_req && !tlb_we && !flt_valid && !wr_en, "R12 reset state",
              {28'h0, busy, rd_req, tlb_we, flt_valid}, 32'h0);
        rst_n = 1;
        // R1 R3 R6: load hits at each primary slot, referenced bit alternating.
        for (int i = 0; i < 8; i++) begin
            fill_group(32'h1000, i, 32'h8123_0000 | i, 32'h0ABC_D002 | ((i % 2) << 8));
            run_miss(2'b01, 32'h7000_0000 + i, 32'h8123_0000 | i, 32'h1000, 32'h2000, 0);
        end
        // R2: secondary hits for fetches.
        for (int i = 0; i < 8; i += 3) begin
            fill_group(32'h3000, 9, 32'h8200_0011, 32'h0);
            fill_group(32'h4000, i, 32'h8200_0051, 32'h0001_1000);
            run_miss(2'b00, 32'h6000_0400 + i, 32'h8200_0011, 32'h3000, 32'h4000, 0);
        end
        // R5: double miss for each kind; R2: compare word already secondary.
        for (int k = 0; k < 3; k++) begin
            fill_group(32'h5000, 9, 32'h8300_0022, 32'h0);
            fill_group(32'h6000, 9, 32'h8300_0062, 32'h0);
            run_miss(2'(k), 32'h1111_0000 + k, 32'h8300_0022, 32'h5000, 32'h6000, 0);
        end
        fill_group(32'h6000, 2, 32'h8300_0062, 32'h0000_2100);
        run_miss(2'b01, 32'h2222_0000, 32'h8300_0062, 32'h5000, 32'h6000, 0);
        fill_group(32'h5000, 9, 32'h8300_0062, 32'h0);
        run_miss(2'b01, 32'h2222_0004, 32'h8300_0062, 32'h5000, 32'h6000, 0);
        // R4: guarded fetch faults; unguarded fetch sets referenced bit.
        fill_group(32'h7000, 4, 32'h8400_0000, 32'h0000_3108);
        run_miss(2'b00, 32'h3333_0000, 32'h8400_0000, 32'h7000, 32'h8000, 0);
        run_miss(2'b01, 32'h3333_0004, 32'h8400_0000, 32'h7000, 32'h8000, 0);
        fill_group(32'h7000, 5, 32'h8400_0001, 32'h0000_3000);
        run_miss(2'b00, 32'h3333_0008, 32'h8400_0001, 32'h7000, 32'h8000, 0);
        // R7: store with changed bit set loads unchanged.
        fill_group(32'h9000, 1, 32'h8500_0000, 32'h0000_4083);
        run_miss(2'b10, 32'h4444_0000, 32'h8500_0000, 32'h9000, 32'hA000, 1);
        // R8 R9: every protection field value with both key values.
        for (int key = 0; key < 2; key++)
            for (int pp = 0; pp < 4; pp++) begin
                fill_group(32'hB000, 6, 32'h8600_0000, 32'h0000_5000 | pp);
                run_miss(2'b10, 32'h5555_0000 + 16 * pp + key, 32'h8600_0000, 32'hB000, 32'hC000, 1'(key));
            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R12 global watchdog", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule